// File: doc/BRIEF.md
# Tag-Routed Memory Response Broadcaster

This block sits at the end of a shared memory path that serves one host result printer and several small processors. Every response returning from memory carries a channel tag, added earlier by the request arbiter, beside its address and read data. The broadcaster reads the tag, removes it, and hands the response to the requester that issued the request. Tag 0 selects the result printer. Tag k+1 selects processor k.

A processor sees its own memory as a narrow address space that was relocated into a wider shared space. Responses bound for a processor therefore lose the high relocation bits and keep only the processor's native address width. The result printer gets the full address. Read data passes through untouched on every path. If a tag names no existing channel, the response is discarded and an error pulse is raised.

One register stage holds the response in flight. Each side uses a valid/ready handshake that tolerates stalls of any length. A stalled destination holds up the whole stream, so responses leave in the order they arrived.

Top module: `mem_resp_router`

## Requirements
- R1: After reset every output valid and the error pulse are low and in_ready is high, and they stay that way until a response is accepted.
- R2: A response accepted with tag 0 appears one cycle later with host_valid high and every proc_valid bit low.
- R3: A response accepted with tag value k+1 (k below NPROC) appears one cycle later with only bit k of proc_valid high and host_valid low.
- R4: host_addr carries all HADDR_W bits of the response address unchanged.
- R5: The processor address slice k (bits k*PADDR_W up to k*PADDR_W+PADDR_W-1 of proc_addr) carries the lowest PADDR_W bits of the response address, and the higher bits are dropped.
- R6: The read data of a response reaches its destination bit-for-bit (host_data, or slice k of proc_data of width DATA_W).
- R7: While the held response's destination ready is low, its valid, address and data stay stable and in_ready is low. in_ready is high when nothing is held or the held response's destination is ready in that cycle.
- R8: A response accepted with a tag value above NPROC is discarded: no output valid rises for it, and err_pulse is high for exactly the one cycle after its acceptance.
- R9: Responses are delivered in acceptance order with no reordering across channels, and one response per cycle gets through when destinations are ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Incoming response valid |
| in_ready | output | 1 | Incoming response accepted this cycle when high with in_valid |
| in_tag | input | TAG_W | Channel tag, TAG_W = clog2(NPROC+1) |
| in_addr | input | HADDR_W | Full shared address |
| in_data | input | DATA_W | Read data |
| host_valid | output | 1 | Response for the result printer valid |
| host_ready | input | 1 | Result printer accepts |
| host_addr | output | HADDR_W | Full address to the result printer |
| host_data | output | DATA_W | Data to the result printer |
| proc_valid | output | NPROC | Per-processor response valid |
| proc_ready | input | NPROC | Per-processor accept |
| proc_addr | output | NPROC*PADDR_W | Per-processor native address, packed |
| proc_data | output | NPROC*DATA_W | Per-processor data, packed |
| err_pulse | output | 1 | One-cycle flag for a dropped out-of-range tag |

## Verification
The embedded assertions check on every cycle that at most one output is valid. They also check that a stalled response holds its valid, address and data, that in_ready falls only while something is held, and that an error pulse always follows an accepted handshake. Which channel a given tag reaches, the exact address truncation, data integrity, arrival order and one-per-cycle throughput only show up when the bench's reference queue is compared against the ports. That comparison runs under directed patterns and under long runs of random tags and back-pressure.

// File: rtl/mem_resp_router.sv
module mem_resp_router #(
  parameter int NPROC   = 4,
  parameter int HADDR_W = 15,
  parameter int PADDR_W = 12,
  parameter int DATA_W  = 12,
  localparam int TAG_W  = $clog2(NPROC + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [TAG_W-1:0]         in_tag,
  input  logic [HADDR_W-1:0]       in_addr,
  input  logic [DATA_W-1:0]        in_data,
  output logic                     host_valid,
  input  logic                     host_ready,
  output logic [HADDR_W-1:0]       host_addr,
  output logic [DATA_W-1:0]        host_data,
  output logic [NPROC-1:0]         proc_valid,
  input  logic [NPROC-1:0]         proc_ready,
  output logic [NPROC*PADDR_W-1:0] proc_addr,
  output logic [NPROC*DATA_W-1:0]  proc_data,
  output logic                     err_pulse
);

  logic               full;
  logic [TAG_W-1:0]   h_tag;
  logic [HADDR_W-1:0] h_addr;
  logic [DATA_W-1:0]  h_data;

  logic [NPROC:0] ch_ready;
  logic [NPROC:0] ch_valid;
  logic           out_fire, take, tag_ok;

  assign ch_ready = {proc_ready, host_ready};
  assign tag_ok   = int'(in_tag) <= NPROC;
  assign out_fire = full && ch_ready[h_tag];
  assign in_ready = !full || out_fire;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      full      <= 1'b0;
      err_pulse <= 1'b0;
    end else begin
      err_pulse <= take && !tag_ok;
      if (take && tag_ok)
        full <= 1'b1;
      else if (out_fire)
        full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take && tag_ok) begin
      h_tag  <= in_tag;
      h_addr <= in_addr;
      h_data <= in_data;
    end
  end

  assign host_valid = full && h_tag == '0;
  assign host_addr  = h_addr;
  assign host_data  = h_data;

  for (genvar k = 0; k < NPROC; k++) begin : g_proc
    assign proc_valid[k] = full && int'(h_tag) == k + 1;
    assign proc_addr[k*PADDR_W +: PADDR_W] = h_addr[PADDR_W-1:0];
    assign proc_data[k*DATA_W +: DATA_W]   = h_data;
  end

  assign ch_valid = {proc_valid, host_valid};

  // R2 R3
  one_dest_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ch_valid));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (|(ch_valid & ~ch_ready)) |=>
      ($stable(ch_valid) && $stable(host_addr) && $stable(host_data)
       && $stable(proc_addr) && $stable(proc_data)));

  // R7
  ready_low_chk: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> (|ch_valid));

  // R8
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> $past(in_valid && in_ready));

  // R8
  err_single_chk: assert property (@(posedge clk) disable iff (rst)
    err_pulse |=> (!err_pulse || $past(in_valid && in_ready)));

endmodule

// File: tb/sim_mem_resp_router.sv
module sim_mem_resp_router;
  localparam int NPROC = 4, HADDR_W = 15, PADDR_W = 12, DATA_W = 12;
  localparam int TAG_W = $clog2(NPROC + 1);

  logic clk = 0, rst = 1;
  logic in_valid = 0, in_ready;
  logic [TAG_W-1:0] in_tag = '0;
  logic [HADDR_W-1:0] in_addr = '0;
  logic [DATA_W-1:0] in_data = '0;
  logic host_valid, host_ready = 0;
  logic [HADDR_W-1:0] host_addr;
  logic [DATA_W-1:0] host_data;
  logic [NPROC-1:0] proc_valid, proc_ready = '0;
  logic [NPROC*PADDR_W-1:0] proc_addr;
  logic [NPROC*DATA_W-1:0] proc_data;
  logic err_pulse;

  int checks = 0, errors = 0, cycles = 0;
  int q_tag[$];
  int q_addr[$];
  int q_data[$];
  bit exp_err = 0;
  bit model_on = 0;

  always #10 clk = ~clk;

  mem_resp_router #(.NPROC(NPROC), .HADDR_W(HADDR_W), .PADDR_W(PADDR_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_tag(in_tag),
    .in_addr(in_addr), .in_data(in_data), .host_valid(host_valid), .host_ready(host_ready),
    .host_addr(host_addr), .host_data(host_data), .proc_valid(proc_valid),
    .proc_ready(proc_ready), .proc_addr(proc_addr), .proc_data(proc_data), .err_pulse(err_pulse));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit dest_ready(input int t);
    if (t == 0) return host_ready;
    return proc_ready[t-1];
  endfunction

  // reference model: one-entry hold, updated at each edge
  always @(posedge clk) begin
    cycles++;
    if (rst || !model_on) begin
      q_tag.delete(); q_addr.delete(); q_data.delete(); exp_err = 0;
    end else begin
      bit fire, acc;
      fire = q_tag.size() > 0 && dest_ready(q_tag[0]);
      acc  = in_valid && (q_tag.size() == 0 || fire);
      if (fire) begin
        void'(q_tag.pop_front()); void'(q_addr.pop_front()); void'(q_data.pop_front());
      end
      exp_err = acc && int'(in_tag) > NPROC;
      if (acc && int'(in_tag) <= NPROC) begin
        q_tag.push_back(int'(in_tag)); q_addr.push_back(int'(in_addr)); q_data.push_back(int'(in_data));
      end
    end
  end

  task automatic compare();
    int ev_host, ev_proc, eready;
    ev_host = 0; ev_proc = 0;
    if (q_tag.size() > 0) begin
      if (q_tag[0] == 0) ev_host = 1; else ev_proc = 1 << (q_tag[0] - 1);
    end
    eready = (q_tag.size() == 0) || dest_ready(q_tag.size() > 0 ? q_tag[0] : 0);
    chk(host_valid == ev_host[0], "R2 host_valid", host_valid, ev_host);
    chk(int'(proc_valid) == ev_proc, "R3 proc_valid", proc_valid, ev_proc);
    chk(in_ready == eready[0], "R7 in_ready", in_ready, eready);
    chk(err_pulse == exp_err, "R8 err_pulse", err_pulse, exp_err);
    if (q_tag.size() > 0) begin
      if (q_tag[0] == 0) begin
        chk(int'(host_addr) == q_addr[0], "R4 host_addr", host_addr, q_addr[0]);
        chk(int'(host_data) == q_data[0], "R6 R9 host_data", host_data, q_data[0]);
      end else begin
        int k = q_tag[0] - 1;
        int ea = q_addr[0] & ((1 << PADDR_W) - 1);
        chk(int'(proc_addr[k*PADDR_W +: PADDR_W]) == ea, "R5 proc_addr", proc_addr[k*PADDR_W +: PADDR_W], ea);
        chk(int'(proc_data[k*DATA_W +: DATA_W]) == q_data[0], "R6 R9 proc_data", proc_data[k*DATA_W +: DATA_W], q_data[0]);
      end
    end
  endtask

  task automatic step(input bit v, input int t, input int a, input int d, input bit hr, input int pr);
    @(negedge clk);
    in_valid = v; in_tag = t[TAG_W-1:0]; in_addr = a[HADDR_W-1:0]; in_data = d[DATA_W-1:0];
    host_ready = hr; proc_ready = pr[NPROC-1:0];
    #1 compare();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: idle after reset
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk(!host_valid && proc_valid == '0 && !err_pulse && in_ready, "R1 reset state",
          {host_valid, proc_valid, err_pulse, in_ready}, 1);
    end
    model_on = 1;
    // R2 R4: host gets full address
    step(1, 0, 15'h7abc, 12'h123, 1, 4'hf);
    step(0, 0, 0, 0, 1, 4'hf);
    // R3 R5: each processor, high bits stripped
    for (int k = 0; k < NPROC; k++) step(1, k + 1, 15'h7000 | (k * 257), 12'h800 + k, 1, 4'hf);
    step(0, 0, 0, 0, 1, 4'hf);
    // R8: out-of-range tags
    step(1, 5, 15'h1111, 12'h222, 1, 4'hf);
    step(1, 7, 15'h1112, 12'h223, 1, 4'hf);
    step(0, 0, 0, 0, 1, 4'hf);
    step(0, 0, 0, 0, 1, 4'hf);
    // R7: stall on processor 2, then a host response waits behind it (R9)
    step(1, 3, 15'h4567, 12'h0aa, 1, 4'h0);
    for (int i = 0; i < 4; i++) step(1, 0, 15'h0555, 12'h0bb, 1, 4'h0);
    step(1, 0, 15'h0555, 12'h0bb, 1, 4'h4);
    step(0, 0, 0, 0, 0, 4'hf);
    step(0, 0, 0, 0, 1, 4'hf);
    // random traffic with back-pressure
    for (int i = 0; i < 4000; i++) begin
      bit v; int t, a, d;
      if (in_valid && !in_ready) begin
        v = 1; t = int'(in_tag); a = int'(in_addr); d = int'(in_data);
      end else begin
        v = ($urandom % 4) != 0; t = $urandom % 8; a = $urandom % (1 << HADDR_W); d = $urandom % (1 << DATA_W);
      end
      step(v, t, a, d, ($urandom % 3) != 0, $urandom % 16);
    end
    step(0, 0, 0, 0, 1, 4'hf);
    step(0, 0, 0, 0, 1, 4'hf);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    errors++;
    checks++;
    $display("FAIL watchdog actual %0d expected %0d", cycles, 100000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule